// File: doc/BRIEF.md
# CCD Field Exposure and Readout Sequencer

This block works at field granularity inside a CCD timing generator. A field-start strobe marks each vertical-drive boundary. At each boundary the block decides three things for the field that begins: whether the sensor-gate transfer pulse may fire, whether the substrate-clear (charge drain) pulses may run, and whether the vertical/horizontal drive outputs stay visible. Line-level pulse placement happens downstream, and it follows these per-field enables.

With no sequence running, the block is in preview behaviour: gate and clear are both allowed in every field. Software writes a five-bit trigger word. At the next field start the block accepts it and can run a long exposure. During that exposure the gate and clear are both held off for a programmed number of fields, and the drive outputs can optionally be masked. The exposure can be followed automatically by a readout phase. In that phase the clear stays off for a programmed number of fields, counted from the field in which the gate fires. Shutter and flash one-shots cover the field in which their trigger bit is accepted.

Top module: `fld_expo_seq`

## Requirements
- R1: After a synchronous active-low reset, gate, clear and drive enables are 1, and busy, shutter and flash are 0.
- R2: With no sequence running, every field has gate and clear enabled. Nonzero exposure or readout lengths without a trigger change nothing.
- R3: Trigger bit positions are: bit 3 starts an exposure, bit 4 requests a readout, bit 1 fires the shutter one-shot and bit 2 fires the flash one-shot. Bit 0 has no effect on any output.
- R4: An accepted exposure of length N>0 gives N consecutive fields with gate and clear disabled and busy high. After those fields, with no readout requested, the following field is a normal one.
- R5: An exposure trigger with length 0 and no readout request yields a normal field with busy low.
- R6: When bits 3 and 4 are accepted together, the field right after the last exposure field has the gate enabled and the clear disabled.
- R7: A readout of length M>0 disables clear for M fields, starting with the gate field. The gate is disabled in the M-1 fields after it. With M=0 the gate field has clear enabled and busy low.
- R8: When the drive-mask input is 1 at acceptance, the drive enable is 0 in exposure fields only. When it is 0, the drive enable stays 1.
- R9: Triggers take effect only at a field start. All outputs stay constant between field starts.
- R10: Trigger writes made while busy is high are discarded, and they do not act after the sequence ends.
- R11: Exposure length, readout length and drive mask are captured at acceptance. Changes made during a sequence do not alter it.
- R12: Shutter and flash outputs are high for exactly the field that starts with the acceptance of bit 1 or bit 2, respectively.
- R13: Bit 4 accepted alone (with readout length M>0) starts the readout at that field: the gate is on and the clear is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_stb | input | 1 | One-cycle pulse at each field boundary |
| trig_wr | input | 1 | Write pulse for the trigger word |
| trig_bits | input | 5 | Trigger word (bit3 exposure, bit4 readout, bit1 shutter, bit2 flash, bit0 unused here) |
| expo_len | input | EXPO_W (12) | Exposure length in fields |
| rdout_len | input | RD_W (3) | Readout clear-suppression length in fields |
| drive_mask | input | 1 | 1 masks drive outputs during exposure |
| gate_en | output | 1 | Sensor-gate transfer allowed this field |
| clear_en | output | 1 | Substrate-clear pulses allowed this field |
| drive_en | output | 1 | Vertical/horizontal drive outputs visible this field |
| busy | output | 1 | A triggered sequence is running |
| shut_pulse | output | 1 | Mechanical shutter one-shot, one field long |
| flash_pulse | output | 1 | Flash one-shot, one field long |

## Verification
Each output is a function of registers that load only on the clock edge that samples field_stb. The result for a new field is therefore due one edge after the strobe, and it holds until the edge of the next strobe. A trigger write moves into a pending register on its own edge. It has no visible effect until the next field start. The bench drives inputs on falling edges. It reads all six outputs on the falling edge that follows the strobe's rising edge, and it also reads them again several cycles into a field to confirm that nothing moved between boundaries.

// File: rtl/fld_seq_pkg.sv
// Package: shared phase encoding and trigger bit positions for the
// field sequencer. Bit positions are part of the software contract.
package fld_seq_pkg;

    localparam int TRIG_BITS = 5;
    localparam int TB_VSUB   = 0;   // reserved here, no effect on outputs
    localparam int TB_SHUT   = 1;
    localparam int TB_FLASH  = 2;
    localparam int TB_EXPO   = 3;
    localparam int TB_RDOUT  = 4;

    // Field phase held for the current field
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,   // preview: gate and clear every field
        PH_EXPO    = 2'd1,   // long exposure field
        PH_RD_GATE = 2'd2,   // first readout field, gate fires
        PH_RD_HOLD = 2'd3    // later readout fields, clear still held off
    } phase_e;

    // Per-field enable bundle produced by the decoder
    typedef struct packed {
        logic gate;
        logic clear;
        logic drive;
        logic busy;
    } fld_en_t;

endpackage

// File: rtl/fld_trig_latch.sv
// Trigger capture.
// Collects trigger writes into a pending word while the sequencer is idle
// and presents it for acceptance at the next field start.
// Assumes: field_stb and trig_wr are single-cycle pulses in the clk domain.
// Writes while busy, or in the cycle of acceptance, are discarded.
module fld_trig_latch
    import fld_seq_pkg::*;
#(
    parameter int TRIG_W = TRIG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_bits,
    input  logic              seq_idle,
    output logic              accept,
    output logic [TRIG_W-1:0] acc_bits
);

    logic [TRIG_W-1:0] pend_q;
    logic              any_pend;

    // Pending trigger is offered only at a field start while idle
    always_comb begin
        any_pend = |pend_q;
        accept   = field_stb && seq_idle && any_pend;
        acc_bits = pend_q;
    end

    // Accumulate idle-time writes; clear on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= '0;
        end else if (trig_wr && seq_idle) begin
            pend_q <= pend_q | trig_bits;
        end
    end

endmodule

// File: rtl/fld_phase_ctrl.sv
// Phase controller.
// Steps the field phase at every field start: idle, exposure countdown,
// readout gate field, readout hold fields. Lengths and the drive mask are
// captured at acceptance so later register writes cannot disturb a sequence.
// Assumes: accept only pulses together with field_stb while in PH_IDLE.
module fld_phase_ctrl
    import fld_seq_pkg::*;
#(
    parameter int EXPO_W = 12,
    parameter int RD_W   = 3,
    parameter int TRIG_W = TRIG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              accept,
    input  logic [TRIG_W-1:0] acc_bits,
    input  logic [EXPO_W-1:0] expo_len,
    input  logic [RD_W-1:0]   rdout_len,
    input  logic              drive_mask,
    output phase_e            phase_q,
    output logic              mask_q
);

    localparam int CNT_W = (EXPO_W > RD_W) ? EXPO_W : RD_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [RD_W-1:0]  rd_len_q, rd_len_d;
    logic             rd_req_q, rd_req_d;
    logic             mask_d;
    phase_e           phase_d;

    logic [CNT_W-1:0] expo_ext, rd_cfg_ext, rd_lat_ext;
    logic             expo_zero, rd_cfg_zero, rd_lat_zero, cnt_zero;

    // Width alignment and zero tests used by the next-state logic
    always_comb begin
        expo_ext    = CNT_W'(expo_len);
        rd_cfg_ext  = CNT_W'(rdout_len);
        rd_lat_ext  = CNT_W'(rd_len_q);
        expo_zero   = (expo_len == '0);
        rd_cfg_zero = (rdout_len == '0);
        rd_lat_zero = (rd_len_q == '0);
        cnt_zero    = (cnt_q == '0);
    end

    // Next phase and remaining-field count at a field start
    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        rd_len_d = rd_len_q;
        rd_req_d = rd_req_q;
        mask_d   = mask_q;
        if (field_stb) begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        rd_len_d = rdout_len;
                        rd_req_d = acc_bits[TB_RDOUT];
                        mask_d   = drive_mask;
                        if (acc_bits[TB_EXPO] && !expo_zero) begin
                            phase_d = PH_EXPO;
                            cnt_d   = expo_ext - CNT_ONE;
                        end else if (acc_bits[TB_RDOUT] && !rd_cfg_zero) begin
                            phase_d = PH_RD_GATE;
                            cnt_d   = rd_cfg_ext - CNT_ONE;
                        end else begin
                            phase_d = PH_IDLE;
                        end
                    end
                end
                PH_EXPO: begin
                    if (!cnt_zero) begin
                        cnt_d = cnt_q - CNT_ONE;
                    end else if (rd_req_q && !rd_lat_zero) begin
                        phase_d = PH_RD_GATE;
                        cnt_d   = rd_lat_ext - CNT_ONE;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
                PH_RD_GATE, PH_RD_HOLD: begin
                    if (!cnt_zero) begin
                        phase_d = PH_RD_HOLD;
                        cnt_d   = cnt_q - CNT_ONE;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase, count and captured configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            rd_len_q <= '0;
            rd_req_q <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            cnt_q    <= cnt_d;
            rd_len_q <= rd_len_d;
            rd_req_q <= rd_req_d;
            mask_q   <= mask_d;
        end
    end

endmodule

// File: rtl/fld_out_decode.sv
// Output decoder.
// Maps the current phase to per-field enables and holds the shutter and
// flash one-shots for exactly the field in which their bits are accepted.
// Assumes: phase and accept come from the same field-start edge logic.
module fld_out_decode
    import fld_seq_pkg::*;
#(
    parameter int TRIG_W = TRIG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              accept,
    input  logic [TRIG_W-1:0] acc_bits,
    input  phase_e            phase_q,
    input  logic              mask_q,
    output fld_en_t           en,
    output logic [1:0]        oneshot
);

    localparam int N_SHOT = 2;
    localparam int SHOT_IDX [N_SHOT] = '{TB_SHUT, TB_FLASH};

    // Phase to enable mapping
    always_comb begin
        en = '{gate: 1'b1, clear: 1'b1, drive: 1'b1, busy: 1'b0};
        case (phase_q)
            PH_EXPO:    en = '{gate: 1'b0, clear: 1'b0, drive: !mask_q, busy: 1'b1};
            PH_RD_GATE: en = '{gate: 1'b1, clear: 1'b0, drive: 1'b1,    busy: 1'b1};
            PH_RD_HOLD: en = '{gate: 1'b0, clear: 1'b0, drive: 1'b1,    busy: 1'b1};
            default:    en = '{gate: 1'b1, clear: 1'b1, drive: 1'b1,    busy: 1'b0};
        endcase
    end

    // One register per one-shot, refreshed at every field start
    for (genvar g = 0; g < N_SHOT; g++) begin : g_shot
        logic shot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shot_q <= 1'b0;
            end else if (field_stb) begin
                shot_q <= accept && acc_bits[SHOT_IDX[g]];
            end
        end
        assign oneshot[g] = shot_q;
    end

endmodule

// File: rtl/fld_expo_seq.sv
// Field exposure and readout sequencer (top).
// Connects trigger capture, phase control and output decode. All outputs
// change only on the clock edge that samples field_stb.
// Assumes: EXPO_W >= 1, RD_W >= 1, single clock domain.
module fld_expo_seq
    import fld_seq_pkg::*;
#(
    parameter int EXPO_W = 12,
    parameter int RD_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 field_stb,
    input  logic                 trig_wr,
    input  logic [TRIG_BITS-1:0] trig_bits,
    input  logic [EXPO_W-1:0]    expo_len,
    input  logic [RD_W-1:0]      rdout_len,
    input  logic                 drive_mask,
    output logic                 gate_en,
    output logic                 clear_en,
    output logic                 drive_en,
    output logic                 busy,
    output logic                 shut_pulse,
    output logic                 flash_pulse
);

    logic                 accept;
    logic [TRIG_BITS-1:0] acc_bits;
    phase_e               phase_q;
    logic                 mask_q;
    logic                 seq_idle;
    fld_en_t              en;
    logic [1:0]           oneshot;

    // Idle indication for trigger capture
    assign seq_idle = (phase_q == PH_IDLE);

    fld_trig_latch #(.TRIG_W(TRIG_BITS)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_stb (field_stb),
        .trig_wr   (trig_wr),
        .trig_bits (trig_bits),
        .seq_idle  (seq_idle),
        .accept    (accept),
        .acc_bits  (acc_bits)
    );

    fld_phase_ctrl #(.EXPO_W(EXPO_W), .RD_W(RD_W), .TRIG_W(TRIG_BITS)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_stb  (field_stb),
        .accept     (accept),
        .acc_bits   (acc_bits),
        .expo_len   (expo_len),
        .rdout_len  (rdout_len),
        .drive_mask (drive_mask),
        .phase_q    (phase_q),
        .mask_q     (mask_q)
    );

    fld_out_decode #(.TRIG_W(TRIG_BITS)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_stb (field_stb),
        .accept    (accept),
        .acc_bits  (acc_bits),
        .phase_q   (phase_q),
        .mask_q    (mask_q),
        .en        (en),
        .oneshot   (oneshot)
    );

    // Port mapping of decoded enables and one-shots
    assign gate_en     = en.gate;
    assign clear_en    = en.clear;
    assign drive_en    = en.drive;
    assign busy        = en.busy;
    assign shut_pulse  = oneshot[0];
    assign flash_pulse = oneshot[1];

endmodule

// File: rtl/fld_expo_seq_chk.sv
// Checker for the field sequencer, attached by bind. Relates outputs over
// time; holds from reset release.
module fld_expo_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic field_stb,
    input logic gate_en,
    input logic clear_en,
    input logic drive_en,
    input logic busy,
    input logic shut_pulse,
    input logic flash_pulse
);

    AST_IDLE_FULL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (gate_en && clear_en && drive_en)); // R2

    AST_HOLD_BETWEEN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable({gate_en, clear_en, drive_en, busy, shut_pulse, flash_pulse})); // R9

    AST_NO_GATE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> (!clear_en && busy)); // R4

    AST_GATE_IN_SEQ_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gate_en) |-> !clear_en); // R7

    AST_DRIVE_MASK_EXPO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (busy && !gate_en && !clear_en)); // R8

    AST_SHUT_AT_FIELD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_pulse) |-> $past(field_stb)); // R12

    AST_FLASH_AT_FIELD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_pulse) |-> $past(field_stb)); // R12

endmodule

bind fld_expo_seq fld_expo_seq_chk u_fld_expo_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_stb   (field_stb),
    .gate_en     (gate_en),
    .clear_en    (clear_en),
    .drive_en    (drive_en),
    .busy        (busy),
    .shut_pulse  (shut_pulse),
    .flash_pulse (flash_pulse)
);

// File: tb/test_fld_expo_seq.sv
// Directed bench for fld_expo_seq. Output vector order:
// {gate, clear, drive, busy, shutter, flash}.
module test_fld_expo_seq;

    localparam int EXPO_W = 12;
    localparam int RD_W   = 3;

    localparam logic [5:0] V_IDLE  = 6'b111000;
    localparam logic [5:0] V_EXPO  = 6'b001100;
    localparam logic [5:0] V_EXPOM = 6'b000100;
    localparam logic [5:0] V_GATE  = 6'b101100;
    localparam logic [5:0] V_HOLD  = 6'b001100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              field_stb = 1'b0;
    logic              trig_wr = 1'b0;
    logic [4:0]        trig_bits = '0;
    logic [EXPO_W-1:0] expo_len = '0;
    logic [RD_W-1:0]   rdout_len = '0;
    logic              drive_mask = 1'b0;
    logic gate_en, clear_en, drive_en, busy, shut_pulse, flash_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fld_expo_seq #(.EXPO_W(EXPO_W), .RD_W(RD_W)) i_fld_expo_seq (
        .clk (clk), .rst_n (rst_n), .field_stb (field_stb), .trig_wr (trig_wr),
        .trig_bits (trig_bits), .expo_len (expo_len), .rdout_len (rdout_len),
        .drive_mask (drive_mask), .gate_en (gate_en), .clear_en (clear_en),
        .drive_en (drive_en), .busy (busy), .shut_pulse (shut_pulse),
        .flash_pulse (flash_pulse)
    );

    function automatic logic [5:0] outs();
        return {gate_en, clear_en, drive_en, busy, shut_pulse, flash_pulse};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, outs(), exp);
        end
    endtask

    // One field boundary; returns on the falling edge after the sampling edge
    task automatic next_field();
        @(negedge clk) field_stb = 1'b1;
        @(negedge clk) field_stb = 1'b0;
    endtask

    task automatic write_trig(input logic [4:0] b);
        @(negedge clk) begin trig_wr = 1'b1; trig_bits = b; end
        @(negedge clk) begin trig_wr = 1'b0; trig_bits = '0; end
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset state", V_IDLE);
    endtask

    task automatic t_preview();
        expo_len = 12'd5; rdout_len = 3'd3;
        for (int i = 0; i < 3; i++) begin
            next_field();
            check("R2 preview field without trigger", V_IDLE);
        end
    endtask

    task automatic t_bit0();
        write_trig(5'b00001);
        next_field();
        check("R3 bit0 has no effect", V_IDLE);
        next_field();
        check("R3 bit0 next field", V_IDLE);
    endtask

    task automatic t_expo_only();
        expo_len = 12'd3; drive_mask = 1'b0;
        write_trig(5'b01000);
        idle_clocks(4);
        check("R9 no effect before field start", V_IDLE);
        for (int i = 0; i < 3; i++) begin
            next_field();
            check("R4 exposure field", V_EXPO);
            idle_clocks(3);
            check("R9 stable inside exposure field", V_EXPO);
        end
        next_field();
        check("R4 normal after exposure", V_IDLE);
    endtask

    task automatic t_expo_zero();
        expo_len = 12'd0;
        write_trig(5'b01000);
        next_field();
        check("R5 zero exposure is normal", V_IDLE);
    endtask

    task automatic t_expo_readout();
        expo_len = 12'd2; rdout_len = 3'd2; drive_mask = 1'b1;
        write_trig(5'b11000);
        next_field(); check("R8 masked exposure field 1", V_EXPOM);
        next_field(); check("R8 masked exposure field 2", V_EXPOM);
        next_field(); check("R6 readout gate field", V_GATE);
        next_field(); check("R7 readout hold field", V_HOLD);
        next_field(); check("R7 idle after readout", V_IDLE);
        drive_mask = 1'b0;
    endtask

    task automatic t_rd_zero();
        expo_len = 12'd1; rdout_len = 3'd0;
        write_trig(5'b11000);
        next_field(); check("R7 exposure before zero readout", V_EXPO);
        next_field(); check("R7 zero readout clears enabled", V_IDLE);
    endtask

    task automatic t_rd_only();
        rdout_len = 3'd1;
        write_trig(5'b10000);
        next_field(); check("R13 readout-only gate field", V_GATE);
        next_field(); check("R13 idle after one readout field", V_IDLE);
    endtask

    task automatic t_busy_write();
        expo_len = 12'd3;
        write_trig(5'b01000);
        next_field(); check("R10 exposure starts", V_EXPO);
        write_trig(5'b00110);
        next_field(); check("R10 exposure field 2", V_EXPO);
        next_field(); check("R10 exposure field 3", V_EXPO);
        next_field(); check("R10 no pulses after sequence", V_IDLE);
        next_field(); check("R10 busy write discarded", V_IDLE);
    endtask

    task automatic t_latch();
        expo_len = 12'd2; rdout_len = 3'd1; drive_mask = 1'b0;
        write_trig(5'b11000);
        next_field(); check("R11 exposure field 1", V_EXPO);
        expo_len = 12'd9; rdout_len = 3'd5; drive_mask = 1'b1;
        next_field(); check("R11 exposure length and mask held", V_EXPO);
        next_field(); check("R11 readout gate", V_GATE);
        next_field(); check("R11 readout length held", V_IDLE);
        drive_mask = 1'b0;
    endtask

    task automatic t_pulses();
        write_trig(5'b00110);
        next_field(); check("R12 shutter and flash field", 6'b111011);
        idle_clocks(5); check("R12 pulses hold within field", 6'b111011);
        next_field(); check("R12 pulses end after one field", V_IDLE);
        write_trig(5'b00100);
        next_field(); check("R3 bit2 drives flash only", 6'b111001);
        write_trig(5'b00010);
        next_field(); check("R3 bit1 drives shutter only", 6'b111010);
        next_field(); check("R12 shutter ends", V_IDLE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle_clocks(4);
        rst_n = 1'b1;
        idle_clocks(1);
        t_reset();
        t_preview();
        t_bit0();
        t_expo_only();
        t_expo_zero();
        t_expo_readout();
        t_rd_zero();
        t_rd_only();
        t_busy_write();
        t_latch();
        t_pulses();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule